// File: doc/BRIEF.md
# Loadable Counter with Optional Divide-by-12 Wrap

This block is a synchronous binary counter. It has three controls and a fixed priority between them: clear, then parallel load, then increment. The register changes only on the rising clock edge. A single parameter sets the counting range. In natural mode the counter runs through every value of its width and rolls over to zero. In divide-by-12 mode a decoder watches for the value 11 and forces a load of zero on the next edge, using the same path as a parallel load, so the sequence runs 0 through 11.

A terminal flag marks the cycle in which the next increment will roll the count over. Clear also acts as the block's synchronous reset. In divide-by-12 mode a value above 11 can still be loaded. Such a value counts up to the top of the range and then rolls over naturally, because the decoder matches 11 only.

Top module: `modwrap_counter`

## Requirements
- R1: When `clr` is 1 at a rising edge, `count` becomes 0, whatever the values of `ld`, `inc` and `din`.
- R2: When `clr` is 0 and `ld` is 1 at a rising edge, `count` takes the value of `din`, whatever `inc` is. This holds in both modes, including when the count is 11 in divide-by-12 mode.
- R3: When `clr` and `ld` are both 0 and no forced wrap applies, `inc`=1 adds one to `count` and `inc`=0 leaves it unchanged.
- R4: In natural mode (`MOD12`=0), an increment from 15 gives 0.
- R5: In divide-by-12 mode (`MOD12`=1), when `count` is 11 and `clr` and `ld` are both 0, the next edge gives 0, whatever `inc` is. The count therefore cycles 0 to 11.
- R6: In divide-by-12 mode, a loaded value of 12 to 15 increments through to 15 and then rolls over to 0.
- R7: `tc` is 1 exactly when `inc` is 1 and `count` equals the last value of the range: 15 in natural mode, 11 in divide-by-12 mode.
- R8: A change on `clr`, `ld`, `inc` or `din` between clock edges does not change `count`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear, highest priority |
| ld | input | 1 | Synchronous parallel load enable |
| inc | input | 1 | Count enable |
| din | input | WIDTH | Parallel load value |
| count | output | WIDTH | Registered count |
| tc | output | 1 | Terminal flag: `inc` is high and the count is at the last value of the range |

## Verification
The register has no power-up value, so the assertions hold no meaning until the first clear. The checker arms itself on the first edge that sees `clr` high. From then on it relates each edge to the controls sampled at the previous one. The assertions assume the controls are free of X once armed. The stimulus meets both conditions: it clears first and always drives every control with a defined level, changing it only on the falling edge.

// File: rtl/modwrap_pkg.sv
package modwrap_pkg;

  // Action chosen for the coming clock edge, listed by priority
  typedef enum logic [2:0] {
    ACT_HOLD  = 3'd0,
    ACT_INC   = 3'd1,
    ACT_WRAP  = 3'd2,
    ACT_LOAD  = 3'd3,
    ACT_CLEAR = 3'd4
  } act_e;

  localparam int unsigned DIV12_LAST = 11;

endpackage

// File: rtl/modwrap_term.sv
module modwrap_term #(
  parameter int unsigned WIDTH = 4,
  parameter bit          MOD12 = 1'b0
) (
  input  logic [WIDTH-1:0] count,
  input  logic             inc,
  output logic             at_last,
  output logic             force_wrap,
  output logic             tc
);
  import modwrap_pkg::*;

  localparam logic [WIDTH-1:0] NAT_LAST = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] D12_LAST = WIDTH'(DIV12_LAST);

  generate
    if (MOD12) begin : g_div12
      // full compare against 11: values above 11 fall through to natural rollover
      assign at_last    = (count == D12_LAST);
      assign force_wrap = at_last;
    end else begin : g_natural
      assign at_last    = (count == NAT_LAST);
      assign force_wrap = 1'b0;
    end
  endgenerate

  assign tc = at_last & inc;

endmodule

// File: rtl/modwrap_ctrl.sv
module modwrap_ctrl (
  input  logic               clr,
  input  logic               ld,
  input  logic               inc,
  input  logic               force_wrap,
  output modwrap_pkg::act_e  act
);
  import modwrap_pkg::*;

  always_comb begin
    if (clr)             act = ACT_CLEAR;
    else if (ld)         act = ACT_LOAD;
    else if (force_wrap) act = ACT_WRAP;
    else if (inc)        act = ACT_INC;
    else                 act = ACT_HOLD;
  end

endmodule

// File: rtl/modwrap_next.sv
module modwrap_next #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0]  count,
  input  logic [WIDTH-1:0]  din,
  input  modwrap_pkg::act_e act,
  output logic [WIDTH-1:0]  nxt
);
  import modwrap_pkg::*;

  logic             use_load;
  logic [WIDTH-1:0] load_val;

  // wrap shares the load path with a zero data word
  assign use_load = (act == ACT_LOAD) || (act == ACT_WRAP);
  assign load_val = (act == ACT_WRAP) ? '0 : din;

  always_comb begin
    if (act == ACT_CLEAR)    nxt = '0;
    else if (use_load)       nxt = load_val;
    else if (act == ACT_INC) nxt = count + 1'b1;
    else                     nxt = count;
  end

endmodule

// File: rtl/modwrap_counter.sv
module modwrap_counter #(
  parameter int unsigned WIDTH = 4,
  parameter bit          MOD12 = 1'b0
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             ld,
  input  logic             inc,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] count,
  output logic             tc
);
  import modwrap_pkg::*;

  logic             at_last;
  logic             force_wrap;
  act_e             act;
  logic [WIDTH-1:0] nxt;

  modwrap_term #(.WIDTH(WIDTH), .MOD12(MOD12)) u_term (
    .count      (count),
    .inc        (inc),
    .at_last    (at_last),
    .force_wrap (force_wrap),
    .tc         (tc)
  );

  modwrap_ctrl u_ctrl (
    .clr        (clr),
    .ld         (ld),
    .inc        (inc),
    .force_wrap (force_wrap),
    .act        (act)
  );

  modwrap_next #(.WIDTH(WIDTH)) u_next (
    .count (count),
    .din   (din),
    .act   (act),
    .nxt   (nxt)
  );

  always_ff @(posedge clk) begin
    count <= nxt;
  end

endmodule

// File: rtl/modwrap_counter_chk.sv
module modwrap_counter_chk #(
  parameter int unsigned WIDTH = 4,
  parameter bit          MOD12 = 1'b0
) (
  input logic             clk,
  input logic             clr,
  input logic             ld,
  input logic             inc,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] count,
  input logic             tc
);
  localparam logic [WIDTH-1:0] LAST_V = MOD12 ? WIDTH'(11) : {WIDTH{1'b1}};

  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    if (clr) armed <= 1'b1;
  end

  assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!armed)
    clr |=> (count == '0));

  assert_load_capture_R2: assert property (@(posedge clk) disable iff (!armed)
    (!clr && ld) |=> (count == $past(din)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!armed)
    (!clr && !ld && !inc && !(MOD12 && count == LAST_V)) |=> $stable(count));

  assert_step_R3: assert property (@(posedge clk) disable iff (!armed)
    (!clr && !ld && inc && !(MOD12 && count == LAST_V)) |=> (count == WIDTH'($past(count) + 1'b1)));

  assert_natural_roll_R4: assert property (@(posedge clk) disable iff (!armed)
    (!MOD12 && !clr && !ld && inc && count == {WIDTH{1'b1}}) |=> (count == '0));

  assert_div12_wrap_R5: assert property (@(posedge clk) disable iff (!armed)
    (MOD12 && !clr && !ld && count == WIDTH'(11)) |=> (count == '0));

  assert_tc_flag_R7: assert property (@(posedge clk) disable iff (!armed)
    tc |-> (inc && count == LAST_V));

endmodule

bind modwrap_counter modwrap_counter_chk #(.WIDTH(WIDTH), .MOD12(MOD12)) u_chk (.*);

// File: tb/test_modwrap_counter.sv
module test_modwrap_counter;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       clr = 1'b1;
  logic       ld  = 1'b0;
  logic       inc = 1'b0;
  logic [3:0] din = 4'd0;
  logic [3:0] cnt_n, cnt_m;
  logic       tc_n, tc_m;

  int checks = 0;
  int errors = 0;
  int mn = 0;
  int mm = 0;
  bit done = 1'b0;

  modwrap_counter #(.WIDTH(4), .MOD12(1'b0)) i_modwrap_counter (
    .clk(clk), .clr(clr), .ld(ld), .inc(inc), .din(din), .count(cnt_n), .tc(tc_n));

  modwrap_counter #(.WIDTH(4), .MOD12(1'b1)) i_modwrap_counter_m12 (
    .clk(clk), .clr(clr), .ld(ld), .inc(inc), .din(din), .count(cnt_m), .tc(tc_m));

  function automatic int model(int c, bit m12, bit cl, bit l, bit i, int d);
    if (cl) return 0;
    if (l) return d;
    if (m12 && c == 11) return 0;
    if (i) return (c + 1) % 16;
    return c;
  endfunction

  task automatic chk(string req, logic [3:0] act, int exp);
    checks++;
    if (act !== 4'(exp)) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(bit c, bit l, bit i, int d, string req);
    @(negedge clk);
    clr = c; ld = l; inc = i; din = 4'(d);
    #1;
    chk("R7 tc natural", {3'b0, tc_n}, (mn == 15 && i) ? 1 : 0);
    chk("R7 tc div12",   {3'b0, tc_m}, (mm == 11 && i) ? 1 : 0);
    chk("R8 no change between edges", cnt_n, mn);
    mn = model(mn, 1'b0, c, l, i, d);
    mm = model(mm, 1'b1, c, l, i, d);
    @(posedge clk);
    #1;
    chk({req, " natural"}, cnt_n, mn);
    chk({req, " div12"},   cnt_m, mm);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(posedge clk);
    #1;
    chk("R1 reset state natural", cnt_n, 0);
    chk("R1 reset state div12", cnt_m, 0);

    // long increment run: natural rolls 15->0 (R4), div12 wraps at 11 (R5)
    for (int k = 0; k < 40; k++) step(1'b0, 1'b0, 1'b1, 0, "R3 R4 R5 increment");
    for (int k = 0; k < 3; k++)  step(1'b0, 1'b0, 1'b0, 0, "R3 hold");

    // exhaustive control/data sweep
    for (int d = 0; d < 16; d++)
      for (int c = 0; c < 8; c++)
        step(c[2], c[1], c[0], d, "R1 R2 R3 sweep");

    // R6: out-of-range load in div12 mode rolls naturally
    step(1'b0, 1'b1, 1'b0, 13, "R6 load 13");
    for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 1'b1, 0, "R6 count past 11");

    // R5: at 11 with inc low the div12 counter still wraps
    step(1'b0, 1'b1, 1'b0, 11, "R2 load 11");
    step(1'b0, 1'b0, 1'b0, 0,  "R5 wrap without inc");

    // R2: external load wins over forced wrap
    step(1'b0, 1'b1, 1'b0, 11, "R2 load 11");
    step(1'b0, 1'b1, 1'b1, 11, "R2 reload at 11");
    step(1'b1, 1'b1, 1'b1, 7,  "R1 clear over load");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule